// File: doc/BRIEF.md
# Warp Register Address Translator

This block sits beside the register file of one partition of a multiprocessor that runs many warps at once. Each resident warp owns a contiguous slice of the partition's 512 rows per lane. The slice is described by a start chunk and a length in chunks, and one chunk is 8 registers. A launcher writes a warp's slice into a small table when the warp starts and clears it when the warp retires. Warps from different kernels may sit side by side with different slice sizes.

On each access the scheduler presents a warp number and an 8-bit logical register number. One cycle later the block returns the 9-bit physical row that every lane of that warp uses. The three low bits of the register number go straight through. The five high bits are added to the warp's start chunk. Logical register 255 always reads as zero and is flagged, so that the storage returns zero on reads and drops writes. An access to a warp with no slice, or to a register beyond its slice, is flagged as a fault, and the row output is then forced to zero. Any warp's mapping can be used in any cycle, so switching warps costs nothing.

Top module: `warp_reg_xlate`

## Requirements
- R1: After reset every table entry is empty, and all outputs (`xl_valid`, `xl_row`, `xl_zero`, `xl_fault`, `ld_err`) are 0. A reset during operation clears the table again.
- R2: One cycle after an access (`acc_valid`=1) to a loaded warp with base chunk B and chunk count C, where register number L ≠ 255 and L[7:3] < C, `xl_row` equals ((B + L[7:3]) × 8 + L[2:0]). `xl_fault` and `xl_zero` are then 0.
- R3: For every non-faulting, non-zero access, `xl_row[2:0]` equals `acc_reg[2:0]` of that access.
- R4: An access with `acc_reg` = 255 gives `xl_zero`=1 and `xl_row`=0, whatever the warp's count. `xl_fault` is 0 if the warp is loaded and 1 if it is not.
- R5: An access to a loaded warp with L ≠ 255 and L[7:3] ≥ C gives `xl_fault`=1 and `xl_row`=0. This includes every such access when C = 0.
- R6: An access to a warp with no table entry gives `xl_fault`=1 and `xl_row`=0.
- R7: A load whose base plus count exceeds 64 raises `ld_err` for exactly one cycle, in the cycle after the load, and leaves the table unchanged. A load whose sum is exactly 64 is accepted.
- R8: A retire empties that warp's entry. Later accesses to that warp fault.
- R9: Entries are independent: loading or retiring one warp does not change another warp's translation. An access in the same cycle as a load or retire of its warp is translated with the entry as it was before that cycle.
- R10: When a load and a retire name the same warp in the same cycle, the load takes effect.
- R11: `xl_valid` equals `acc_valid` delayed by one cycle. When `xl_valid` is 0, `xl_row`, `xl_zero` and `xl_fault` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Load a warp's slice into the table |
| ld_warp | input | 4 | Warp number for the load |
| ld_base | input | 6 | First chunk of the slice |
| ld_count | input | 6 | Slice length in 8-register chunks |
| ret_en | input | 1 | Retire (clear) a warp's entry |
| ret_warp | input | 4 | Warp number for the retire |
| ld_err | output | 1 | One-cycle pulse: last load was rejected |
| acc_valid | input | 1 | Translation request |
| acc_warp | input | 4 | Warp number of the request |
| acc_reg | input | 8 | Logical register number |
| xl_valid | output | 1 | Result valid, one cycle after the request |
| xl_row | output | 9 | Physical register-file row |
| xl_zero | output | 1 | Request named the zero register |
| xl_fault | output | 1 | Empty warp or register outside the slice |

## Verification
The bench loads all sixteen warps with distinct slices and then sweeps every register number of every warp. Each sweep checks the chunk boundary at the count. A design that compares with the wrong inequality would map one register past the slice or fault on the last one. Slices that end exactly at row 511, and a 32-chunk slice that spans the whole logical range, expose adders that wrap or truncate. The rejected load at 65 chunks catches a design that writes the table before it checks the span. Accesses in the same cycle as a load or retire of the same warp, and a load and retire that collide, catch designs that forward new entries early or apply the clear last. Register 255 on an empty warp and on a zero-count warp catches a design that lets the fault logic mask the zero flag.

// File: rtl/wrx_pkg.sv
`timescale 1ns/1ps
package wrx_pkg;
    // Configuration of one partition's register file
    localparam int unsigned WARPS    = 16;
    localparam int unsigned LREG_W   = 8;
    localparam int unsigned PROW_W   = 9;
    localparam int unsigned GRAN_W   = 3;
    // Derived widths
    localparam int unsigned WID_W    = $clog2(WARPS);
    localparam int unsigned CHUNK_W  = PROW_W - GRAN_W;
    localparam int unsigned LCHUNK_W = LREG_W - GRAN_W;
    localparam int unsigned CHUNKS   = 1 << CHUNK_W;
    localparam logic [LREG_W-1:0] ZERO_REG = '1;

    typedef struct packed {
        logic               vld;
        logic [CHUNK_W-1:0] base;
        logic [CHUNK_W-1:0] cnt;
    } wtab_ent_t;

    typedef struct packed {
        logic              vld;
        logic [PROW_W-1:0] row;
        logic              zero;
        logic              fault;
    } xl_res_t;

    // True when a slice of cnt chunks starting at base stays inside the file
    function automatic logic span_fits(input logic [CHUNK_W-1:0] base,
                                       input logic [CHUNK_W-1:0] cnt);
        logic [CHUNK_W:0] sum;
        sum = {1'b0, base} + {1'b0, cnt};
        return sum <= (CHUNK_W+1)'(CHUNKS);
    endfunction
endpackage

// File: rtl/wrx_table.sv
`timescale 1ns/1ps
module wrx_table
    import wrx_pkg::*;
#(
    parameter int unsigned N_ENT = WARPS,
    localparam int unsigned IW   = $clog2(N_ENT)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ld_en,
    input  logic [IW-1:0]      ld_idx,
    input  logic [CHUNK_W-1:0] ld_base,
    input  logic [CHUNK_W-1:0] ld_cnt,
    input  logic               ret_en,
    input  logic [IW-1:0]      ret_idx,
    input  logic [IW-1:0]      rd_idx,
    output wtab_ent_t          rd_ent,
    output logic               ld_err
);
    typedef struct packed {
        wtab_ent_t [N_ENT-1:0] ent;
        logic                  err;
    } tab_state_t;

    tab_state_t s_d, s_q;
    logic       fits;

    assign fits = span_fits(ld_base, ld_cnt);

    always_comb begin
        s_d     = s_q;
        s_d.err = 1'b0;
        // Retire is applied first so a colliding load survives
        for (int i = 0; i < N_ENT; i++) begin
            if (ret_en && (ret_idx == IW'(i))) begin
                s_d.ent[i] = '0;
            end
            if (ld_en && fits && (ld_idx == IW'(i))) begin
                s_d.ent[i].vld  = 1'b1;
                s_d.ent[i].base = ld_base;
                s_d.ent[i].cnt  = ld_cnt;
            end
        end
        if (ld_en && !fits) begin
            s_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_ent = s_q.ent[rd_idx];
    assign ld_err = s_q.err;
endmodule

// File: rtl/wrx_lookup.sv
`timescale 1ns/1ps
module wrx_lookup
    import wrx_pkg::*;
(
    input  logic              req,
    input  wtab_ent_t         ent,
    input  logic [LREG_W-1:0] lreg,
    output xl_res_t           res
);
    logic                is_zero;
    logic [LCHUNK_W-1:0] lchunk;
    logic                beyond;
    logic                fault;
    logic [CHUNK_W-1:0]  pchunk;

    always_comb begin
        is_zero = (lreg == ZERO_REG);
        lchunk  = lreg[LREG_W-1:GRAN_W];
        beyond  = !is_zero && (CHUNK_W'(lchunk) >= ent.cnt);
        fault   = !ent.vld || beyond;
        pchunk  = ent.base + CHUNK_W'(lchunk);
        res     = '0;
        if (req) begin
            res.vld   = 1'b1;
            res.zero  = is_zero;
            res.fault = fault;
            if (!fault && !is_zero) begin
                res.row = {pchunk, lreg[GRAN_W-1:0]};
            end
        end
    end
endmodule

// File: rtl/warp_reg_xlate.sv
`timescale 1ns/1ps
module warp_reg_xlate
    import wrx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ld_en,
    input  logic [WID_W-1:0]   ld_warp,
    input  logic [CHUNK_W-1:0] ld_base,
    input  logic [CHUNK_W-1:0] ld_count,
    input  logic               ret_en,
    input  logic [WID_W-1:0]   ret_warp,
    output logic               ld_err,
    input  logic               acc_valid,
    input  logic [WID_W-1:0]   acc_warp,
    input  logic [LREG_W-1:0]  acc_reg,
    output logic               xl_valid,
    output logic [PROW_W-1:0]  xl_row,
    output logic               xl_zero,
    output logic               xl_fault
);
    wtab_ent_t cur_ent;
    xl_res_t   res_d, res_q;

    wrx_table #(.N_ENT(WARPS)) i_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_en   (ld_en),
        .ld_idx  (ld_warp),
        .ld_base (ld_base),
        .ld_cnt  (ld_count),
        .ret_en  (ret_en),
        .ret_idx (ret_warp),
        .rd_idx  (acc_warp),
        .rd_ent  (cur_ent),
        .ld_err  (ld_err)
    );

    wrx_lookup i_lookup (
        .req  (acc_valid),
        .ent  (cur_ent),
        .lreg (acc_reg),
        .res  (res_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign xl_valid = res_q.vld;
    assign xl_row   = res_q.row;
    assign xl_zero  = res_q.zero;
    assign xl_fault = res_q.fault;
endmodule

// File: rtl/wrx_chk.sv
`timescale 1ns/1ps
module wrx_chk
    import wrx_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               ld_en,
    input logic [WID_W-1:0]   ld_warp,
    input logic [CHUNK_W-1:0] ld_base,
    input logic [CHUNK_W-1:0] ld_count,
    input logic               ret_en,
    input logic [WID_W-1:0]   ret_warp,
    input logic               ld_err,
    input logic               acc_valid,
    input logic [WID_W-1:0]   acc_warp,
    input logic [LREG_W-1:0]  acc_reg,
    input logic               xl_valid,
    input logic [PROW_W-1:0]  xl_row,
    input logic               xl_zero,
    input logic               xl_fault
);
    // R11
    valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> xl_valid);
    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xl_valid |-> (xl_row == '0 && !xl_zero && !xl_fault));
    // R5
    fault_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xl_fault |-> (xl_row == '0));
    // R4
    zero_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && (acc_reg == ZERO_REG) |=> (xl_zero && xl_row == '0));
    // R3
    low_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && (acc_reg != ZERO_REG) |=>
            (xl_fault || xl_row[GRAN_W-1:0] == $past(acc_reg[GRAN_W-1:0])));
    // R7
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en && !span_fits(ld_base, ld_count) |=> ld_err);
    // R7
    err_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_en && !span_fits(ld_base, ld_count)) |=> !ld_err);
endmodule

bind warp_reg_xlate wrx_chk i_wrx_chk (.*);

// File: tb/test_warp_reg_xlate.sv
`timescale 1ns/1ps
module test_warp_reg_xlate;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       ld_en, ret_en, acc_valid;
    logic [3:0] ld_warp, ret_warp, acc_warp;
    logic [5:0] ld_base, ld_count;
    logic [7:0] acc_reg;
    logic       ld_err, xl_valid, xl_zero, xl_fault;
    logic [8:0] xl_row;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    bit mv[16];
    int mb[16];
    int mc[16];

    always #2 clk = ~clk;

    warp_reg_xlate i_warp_reg_xlate (
        .clk(clk), .rst_n(rst_n),
        .ld_en(ld_en), .ld_warp(ld_warp), .ld_base(ld_base), .ld_count(ld_count),
        .ret_en(ret_en), .ret_warp(ret_warp), .ld_err(ld_err),
        .acc_valid(acc_valid), .acc_warp(acc_warp), .acc_reg(acc_reg),
        .xl_valid(xl_valid), .xl_row(xl_row), .xl_zero(xl_zero), .xl_fault(xl_fault)
    );

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: got {v,row,z,f}=%h expected %h", req, act, exp);
        end
    endtask

    // One clock: optional load, retire and access, checked against the model
    task automatic cyc(input bit l, input int lw, input int lb, input int lc,
                       input bit r, input int rw,
                       input bit a, input int aw, input int ar, input string tag);
        bit ev, ez, ef, fit;
        int erow;
        string req;
        @(negedge clk);
        ld_en = l; ld_warp = 4'(lw); ld_base = 6'(lb); ld_count = 6'(lc);
        ret_en = r; ret_warp = 4'(rw);
        acc_valid = a; acc_warp = 4'(aw); acc_reg = 8'(ar);
        ev = a; ez = 0; ef = 0; erow = 0; req = "R11";
        if (a) begin
            ez = (ar == 255);
            ef = !mv[aw] || (!ez && ((ar >> 3) >= mc[aw]));
            if (!ef && !ez) erow = ((mb[aw] + (ar >> 3)) % 64) * 8 + (ar % 8);
            if (ez) req = "R4";
            else if (!mv[aw]) req = "R6";
            else if (ef) req = "R5";
            else req = "R2";
        end
        if (tag != "") req = tag;
        fit = (lb + lc) <= 64;
        @(posedge clk);
        #1;
        ld_en = 0; ret_en = 0; acc_valid = 0;
        check(req, {xl_valid, xl_row, xl_zero, xl_fault}, {ev, 9'(erow), ez, ef});
        if (l) check("R7", {11'd0, ld_err}, {11'd0, !fit});
        if (r) mv[rw] = 0;
        if (l && fit) begin mv[lw] = 1; mb[lw] = lb; mc[lw] = lc; end
    endtask

    task automatic acc(input int w, input int rg, input string tag);
        cyc(0, 0, 0, 0, 0, 0, 1, w, rg, tag);
    endtask

    task automatic load(input int w, input int b, input int c, input string tag);
        cyc(1, w, b, c, 0, 0, 0, 0, 0, tag);
    endtask

    initial begin
        #800000;
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) begin mv[i] = 0; mb[i] = 0; mc[i] = 0; end
        rst_n = 0; ld_en = 0; ret_en = 0; acc_valid = 0;
        ld_warp = 0; ret_warp = 0; acc_warp = 0; ld_base = 0; ld_count = 0; acc_reg = 0;
        repeat (3) @(posedge clk);
        #1;
        // R1: outputs idle in reset
        check("R1", {xl_valid, xl_row, xl_zero, xl_fault, 1'b0}, 12'd0);
        check("R1", {11'd0, ld_err}, 12'd0);
        @(negedge clk);
        rst_n = 1;
        // R1: every entry empty after reset
        for (int w = 0; w < 16; w++) acc(w, 0, "R1");
        // R11: idle cycle
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, "R11");

        // R9: load all warps with distinct slices
        for (int w = 0; w < 16; w++) load(w, w * 4, (w % 4) + 1, "R9");
        // Full sweep of every warp and register (R2, R4, R5)
        for (int w = 0; w < 16; w++)
            for (int rg = 0; rg < 256; rg++) acc(w, rg, "");
        // R3: low bits inside one chunk
        for (int rg = 24; rg < 32; rg++) acc(3, rg, "R3");

        // R7: overflowing load rejected, table untouched
        load(2, 60, 5, "R7");
        for (int rg = 0; rg < 40; rg++) acc(2, rg, "");
        // R7: exact fit up to row 511
        load(5, 63, 1, "R7");
        acc(5, 7, "R7");
        acc(5, 8, "R5");

        // R2: 32-chunk slice spanning the whole logical range
        load(0, 32, 32, "R2");
        for (int rg = 0; rg < 256; rg++) acc(0, rg, "");

        // R5: zero count faults every register but 255
        load(9, 40, 0, "R5");
        for (int rg = 240; rg < 256; rg++) acc(9, rg, "");

        // R8: retire clears the entry
        cyc(0, 0, 0, 0, 1, 7, 0, 0, 0, "R8");
        acc(7, 0, "R8");
        acc(7, 13, "R8");
        // R4: zero register on an empty warp also faults
        acc(7, 255, "R4");
        // R9: neighbour unaffected by retire
        acc(6, 9, "R9");

        // R9: access in the same cycle as a load sees the old entry
        cyc(1, 7, 10, 2, 0, 0, 1, 7, 0, "R9");
        acc(7, 0, "R9");
        acc(7, 15, "R9");
        // R9: access in the same cycle as a retire sees the old entry
        cyc(0, 0, 0, 0, 1, 7, 1, 7, 5, "R9");
        acc(7, 5, "R9");

        // R10: load and retire collide, load wins
        cyc(1, 8, 20, 1, 1, 8, 0, 0, 0, "R10");
        acc(8, 3, "R10");
        acc(8, 8, "R10");

        // R1: reset during operation clears the table
        @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        for (int i = 0; i < 16; i++) mv[i] = 0;
        acc(4, 0, "R1");
        acc(8, 3, "R1");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule